// File: doc/BRIEF.md
# Delayed-Branch Next-PC Unit

This block sequences the program counter of a processor with one architectural delay slot. It holds the address of the instruction now executing (PC) and of the one after it (NPC). From the current instruction word it forms the address that NPC takes next. Each time an instruction retires (`adv_en` high), PC takes NPC and NPC takes that computed value.

For a branch, the unit extracts the displacement from the instruction word. The displacement comes in one of three contiguous widths or in a split two-field layout. The unit sign-extends it, adds it to the branch's own PC to form the target, and then picks one of three moves: jump to the target, fall through, or fall through while skipping the delay slot. The condition result comes from outside. The annul bit in the word and an unconditional flag select the variant. A taken unconditional branch with annul marks its delay slot as squashed. A squashed slot is retired as a plain sequential instruction whatever its word contains. The unit also presents the sign-extended 13-bit immediate of the register-plus-immediate form.

Top module: `dbr_npc_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released, `pc` equals RESET_VEC, `npc` equals RESET_VEC+4 and `squash` is 0.
- R2: With `disp_fmt` 0, 1 or 2, the field width N is 19, 22 or 30. `target` is `pc` plus the low N bits of `instr` shifted left by 2 and sign-extended from bit N+1.
- R3: With `disp_fmt` 3, the displacement is `instr[21:20]` at bits 17:16 and `instr[13:0]` at bits 15:2, with bits 1:0 zero, sign-extended from bit 17. `target` is `pc` plus this displacement.
- R4: A branch that is not squashed, with `uncond` 0 and `cond_true` 1, is taken. `nnpc` shows `target`. On retire `pc` takes the old `npc`, `npc` takes `target` and `squash` goes to 0, whatever the annul bit `instr[29]`.
- R5: A conditional branch that is not taken and has `instr[29]` 0 retires sequentially: `pc` takes the old `npc`, and `npc` takes the old `npc`+4.
- R6: A conditional branch that is not taken and has `instr[29]` 1 skips its delay slot: `pc` takes the old `npc`+4 and `npc` takes the old `npc`+8. `nnpc` shows the old `npc`+8.
- R7: A branch with `uncond` 1 is taken whatever `cond_true` is. If `instr[29]` is 1, `squash` is 1 after retire. Otherwise it is 0.
- R8: When `is_branch` is 0, retire is sequential: `pc` takes the old `npc`, `npc` takes the old `npc`+4, and `nnpc` shows the old `npc`+4.
- R9: While `adv_en` is 0, `pc`, `npc` and `squash` hold their values.
- R10: While `squash` is 1, the instruction at `pc` is treated as non-branch whatever `is_branch` and `uncond` are. It retires sequentially and clears `squash`.
- R11: `imm_sext` is `instr[12:0]` sign-extended to the address width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_en | input | 1 | Current instruction retires this cycle |
| instr | input | 32 | Current instruction word |
| is_branch | input | 1 | Word is a PC-relative branch |
| uncond | input | 1 | Branch is unconditional |
| cond_true | input | 1 | Evaluated branch condition |
| disp_fmt | input | 2 | Displacement layout: 0/1/2 = 19/22/30-bit field, 3 = split |
| pc | output | ADDR_W | Address of current instruction |
| npc | output | ADDR_W | Address of following instruction |
| nnpc | output | ADDR_W | Value NPC takes on retire |
| target | output | ADDR_W | Branch target, pc plus displacement |
| imm_sext | output | ADDR_W | Sign-extended 13-bit immediate |
| squash | output | 1 | Instruction at pc is an annulled delay slot |

## Verification
On every cycle the assertions check several behaviours: that state holds while retire is off, that skip and squash set the right addresses after a retire, and that a squashed slot always advances sequentially. Only the bench shows that each displacement layout yields the right target. The bench also covers the exact bit positions of the split field, and that conditional taken, not-taken and annulled branches chain correctly over long random instruction streams against an independent address model.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
  localparam int INSTR_W   = 32;
  localparam int ANNUL_BIT = 29;
  localparam int IMM_W     = 13;

  typedef enum logic [1:0] {
    FMT_D19   = 2'd0,
    FMT_D22   = 2'd1,
    FMT_D30   = 2'd2,
    FMT_SPLIT = 2'd3
  } disp_fmt_e;

  typedef enum logic [1:0] {
    STEP_SEQ  = 2'd0,
    STEP_JUMP = 2'd1,
    STEP_SKIP = 2'd2
  } step_e;

  function automatic int nbit_width(input int idx);
    case (idx)
      0:       return 19;
      1:       return 22;
      default: return 30;
    endcase
  endfunction
endpackage

// File: rtl/dbr_disp_ext.sv
module dbr_disp_ext
  import dbr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [INSTR_W-1:0] instr,
  input  logic [1:0]         fmt,
  output logic [ADDR_W-1:0]  disp,
  output logic [ADDR_W-1:0]  imm
);
  localparam int NUM_NBIT = 3;
  localparam int SPLIT_W  = 18;

  logic [ADDR_W-1:0] cand [4];

  // contiguous N-bit word displacements
  for (genvar g = 0; g < NUM_NBIT; g++) begin : g_nbit
    localparam int FW = nbit_width(g);
    localparam int SW = FW + 2;
    logic [SW-1:0] raw;
    assign raw     = {instr[FW-1:0], 2'b00};
    assign cand[g] = ADDR_W'($signed(raw));
  end

  // split layout: high pair at 21:20, low 14 bits at 13:0
  logic [SPLIT_W-1:0] split_raw;
  assign split_raw = {instr[21:20], instr[13:0], 2'b00};
  assign cand[3]   = ADDR_W'($signed(split_raw));

  always_comb begin
    disp = cand[fmt];
    imm  = ADDR_W'($signed(instr[IMM_W-1:0]));
  end
endmodule

// File: rtl/dbr_step_ctrl.sv
module dbr_step_ctrl
  import dbr_pkg::*;
(
  input  logic  is_branch,
  input  logic  uncond,
  input  logic  cond_true,
  input  logic  annul,
  input  logic  slot_squashed,
  output step_e step,
  output logic  squash_d
);
  always_comb begin
    step     = STEP_SEQ;
    squash_d = 1'b0;
    if (!slot_squashed && is_branch) begin
      if (uncond || cond_true) begin
        step     = STEP_JUMP;
        squash_d = uncond && annul;
      end else if (annul) begin
        step = STEP_SKIP;
      end
    end
  end
endmodule

// File: rtl/dbr_npc_unit.sv
module dbr_npc_unit
  import dbr_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv_en,
  input  logic [INSTR_W-1:0]  instr,
  input  logic                is_branch,
  input  logic                uncond,
  input  logic                cond_true,
  input  logic [1:0]          disp_fmt,
  output logic [ADDR_W-1:0]   pc,
  output logic [ADDR_W-1:0]   npc,
  output logic [ADDR_W-1:0]   nnpc,
  output logic [ADDR_W-1:0]   target,
  output logic [ADDR_W-1:0]   imm_sext,
  output logic                squash
);
  localparam logic [ADDR_W-1:0] WORD   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] DWORD  = ADDR_W'(8);

  logic [ADDR_W-1:0] pc_q, npc_q, pc_d, npc_d, disp;
  logic              squash_q, squash_d;
  step_e             step;

  dbr_disp_ext #(.ADDR_W(ADDR_W)) u_disp (
    .instr (instr),
    .fmt   (disp_fmt),
    .disp  (disp),
    .imm   (imm_sext)
  );

  dbr_step_ctrl u_ctrl (
    .is_branch     (is_branch),
    .uncond        (uncond),
    .cond_true     (cond_true),
    .annul         (instr[ANNUL_BIT]),
    .slot_squashed (squash_q),
    .step          (step),
    .squash_d      (squash_d)
  );

  always_comb begin
    target = pc_q + disp;
    case (step)
      STEP_JUMP: begin pc_d = npc_q;        npc_d = target;        end
      STEP_SKIP: begin pc_d = npc_q + WORD; npc_d = npc_q + DWORD; end
      default:   begin pc_d = npc_q;        npc_d = npc_q + WORD;  end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= RESET_VEC;
      npc_q    <= RESET_VEC + WORD;
      squash_q <= 1'b0;
    end else if (adv_en) begin
      pc_q     <= pc_d;
      npc_q    <= npc_d;
      squash_q <= squash_d;
    end
  end

  assign pc     = pc_q;
  assign npc    = npc_q;
  assign nnpc   = npc_d;
  assign squash = squash_q;

  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_en |=> ($stable(pc_q) && $stable(npc_q) && $stable(squash_q)));

  // R10
  squashed_slot_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && squash_q) |=>
      (!squash_q && pc_q == $past(npc_q) && npc_q == $past(npc_q) + WORD));

  // R6
  annul_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && !squash_q && is_branch && !uncond && !cond_true && instr[ANNUL_BIT])
      |=> (pc_q == $past(npc_q) + WORD && npc_q == $past(npc_q) + DWORD));

  // R7
  uncond_annul_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && !squash_q && is_branch && uncond && instr[ANNUL_BIT]) |=> squash_q);

  // R8
  plain_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && !is_branch) |=> (pc_q == $past(npc_q) && npc_q == $past(npc_q) + WORD));
endmodule

// File: tb/dbr_npc_unit_tb.sv
`timescale 1ns/1ps
module dbr_npc_unit_tb;
  localparam logic [31:0] RV = 32'h0000_1000;

  logic        clk = 0, rst_n = 0, adv_en = 0, is_branch = 0, uncond = 0, cond_true = 0;
  logic [31:0] instr = '0;
  logic [1:0]  disp_fmt = '0;
  logic [31:0] pc, npc, nnpc, target, imm_sext;
  logic        squash;

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_pc, m_npc;
  logic        m_sq;

  dbr_npc_unit #(.ADDR_W(32), .RESET_VEC(RV)) u_dut (
    .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .instr(instr), .is_branch(is_branch),
    .uncond(uncond), .cond_true(cond_true), .disp_fmt(disp_fmt), .pc(pc), .npc(npc),
    .nnpc(nnpc), .target(target), .imm_sext(imm_sext), .squash(squash));

  always #5 clk = ~clk;

  function automatic logic [31:0] ref_disp(input logic [31:0] w, input logic [1:0] f);
    case (f)
      2'd0:    return {{11{w[18]}}, w[18:0], 2'b00};
      2'd1:    return {{8{w[21]}}, w[21:0], 2'b00};
      2'd2:    return {w[29:0], 2'b00};
      default: return {{14{w[21]}}, w[21:20], w[13:0], 2'b00};
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_step(input logic a, input logic b, input logic u, input logic c,
                         input logic [1:0] f, input logic [31:0] w);
    logic [31:0] tgt, e_pc, e_npc;
    logic        e_sq;
    string       tag;
    adv_en = a; is_branch = b; uncond = u; cond_true = c; disp_fmt = f; instr = w;
    #1;
    tgt = m_pc + ref_disp(w, f);
    chk(f == 2'd3 ? "R3" : "R2", target, tgt);
    chk("R11", imm_sext, {{19{w[12]}}, w[12:0]});
    e_sq = 0;
    if (m_sq || !b)       begin e_pc = m_npc;     e_npc = m_npc + 4; end
    else if (u || c)      begin e_pc = m_npc;     e_npc = tgt; e_sq = u && w[29]; end
    else if (w[29])       begin e_pc = m_npc + 4; e_npc = m_npc + 8; end
    else                  begin e_pc = m_npc;     e_npc = m_npc + 4; end
    if (!a)        tag = "R9";
    else if (m_sq) tag = "R10";
    else if (!b)   tag = "R8";
    else if (u)    tag = "R7";
    else if (c)    tag = "R4";
    else if (w[29]) tag = "R6";
    else           tag = "R5";
    chk(tag, nnpc, e_npc);
    if (a) begin m_pc = e_pc; m_npc = e_npc; m_sq = e_sq; end
    @(negedge clk);
    chk(tag, pc, m_pc);
    chk(tag, npc, m_npc);
    chk(tag, {31'd0, squash}, {31'd0, m_sq});
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk("R1", pc, RV); chk("R1", npc, RV + 4); chk("R1", {31'd0, squash}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", pc, RV); chk("R1", npc, RV + 4); chk("R1", {31'd0, squash}, 0);
    m_pc = RV; m_npc = RV + 4; m_sq = 0;
    // R2: negative 19-bit, max positive 22-bit, negative 30-bit
    do_step(1, 1, 0, 1, 2'd0, 32'h0004_0001);
    do_step(1, 1, 0, 1, 2'd1, 32'h001F_FFFF);
    do_step(1, 1, 0, 1, 2'd2, 32'h3FFF_FFF0);
    // R3: split with high pair 2'b10 (negative), then positive
    do_step(1, 1, 0, 1, 2'd3, 32'h0020_0005);
    do_step(1, 1, 0, 1, 2'd3, 32'h0010_3FFF);
    // R4: taken conditional with annul keeps the slot
    do_step(1, 1, 0, 1, 2'd0, 32'h2000_0010);
    // R5, R6
    do_step(1, 1, 0, 0, 2'd0, 32'h0000_0010);
    do_step(1, 1, 0, 0, 2'd0, 32'h2000_0010);
    // R7: uncond with cond false, annul -> squash; then R10 squashed branch slot
    do_step(1, 1, 1, 0, 2'd1, 32'h2000_0040);
    do_step(1, 1, 1, 1, 2'd0, 32'h2000_0100);
    do_step(1, 1, 1, 0, 2'd1, 32'h0000_0040);
    // R9: hold with a branch presented
    do_step(0, 1, 1, 1, 2'd2, 32'h2000_0800);
    // R8
    do_step(1, 0, 1, 1, 2'd0, 32'h2000_0008);
    // R11: negative immediate
    do_step(1, 0, 0, 0, 2'd0, 32'h0000_1FFF);
    for (int i = 0; i < 600; i++) begin
      do_step(($urandom % 8) != 0, ($urandom % 3) != 0, ($urandom % 4) == 0,
              $urandom % 2, 2'($urandom % 4), $urandom);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule